// File: doc/BRIEF.md
# Configuration File Header Skipper

This block sits in front of a loader that expects raw configuration payload. It reads a configuration file as a byte stream, throws away the descriptive header at the front, and finds where the payload begins. From that byte to the end of the file it forwards every byte downstream. The first forwarded byte carries a start flag, and every forwarded byte carries its position within the payload.

The header is walked as four length-prefixed records. The first record's length byte is at a fixed offset of 15. Each length byte L moves the walk to the byte L + 3 further on. Once the fourth record has been passed, the block searches for a preamble. A mode input selects between two preamble styles.

In plain mode, a run of four 0xFF bytes marks the payload, and those four bytes are forwarded as its first bytes. In compressed mode, the marker is a 0xFF followed by a byte whose upper nibble is 3. Both marker bytes are dropped, and the payload begins with the byte after them. If the file ends before any marker is seen, the block pulses an error and forwards nothing.

Top module: `cfg_hdr_skip`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `err` is 0.
- R2: Bytes before offset 15 and every byte inside the four header records are never taken as preamble bytes, even when they hold 0xFF runs or 0xFF followed by 0x3X. The walk works as follows. The length byte L of a record at index p puts the next record's length byte at p + L + 3. The search begins at the index reached after the fourth record.
- R3: With `mode_comp` = 0, the payload starts at the first of four consecutive 0xFF bytes in the search region. Those four bytes are forwarded as payload.
- R4: With `mode_comp` = 1, the payload starts at the byte after a 0xFF that is followed by a byte with bits [7:4] = 4'h3. Neither marker byte is forwarded. A 0xFF followed by any other upper nibble does not match.
- R5: A marker is detected wherever it falls in the search region, including after shorter partial runs. A run longer than four 0xFF bytes starts the payload at the first 0xFF of the run.
- R6: Every byte from the payload start to the byte marked by `in_last` is forwarded unchanged and in order. Exactly (file size − start index) bytes are forwarded. `out_last` is set on the final one only.
- R7: `out_sop` is 1 on the first payload byte of a file and 0 on all others. `out_cnt` is 0 on that byte and rises by one on each following byte.
- R8: While `out_valid` is 1 and `out_ready` is 0, all output fields hold their values, and no byte is lost or duplicated under any stall pattern.
- R9: If `in_last` arrives before a marker, or on the second byte of a compressed marker, `err` pulses for one cycle and no payload byte is forwarded.
- R10: After a file's last byte, the next accepted byte is treated as offset 0 of a new file, with no idle cycle needed between files.
- R11: Header and search bytes are accepted with `in_ready` held at 1, even while the output is stalled (when no plain-mode marker replay is pending).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_comp | input | 1 | Preamble style: 0 = four 0xFF bytes, 1 = 0xFF then 0x3X |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the last of the file |
| out_valid | output | 1 | Output payload byte valid |
| out_ready | input | 1 | Downstream can take the output byte |
| out_data | output | 8 | Payload byte |
| out_sop | output | 1 | First payload byte of the file |
| out_last | output | 1 | Last payload byte of the file |
| out_cnt | output | CNT_W | Position of the byte within the payload |
| err | output | 1 | One-cycle pulse: file ended with no payload |

## Verification
The assertions assume the following about the inputs:
- `mode_comp` stays constant for the whole of a file.
- An offered input byte, with its `in_last`, holds until it is accepted.
- A file is shorter than 2^IDX_W bytes, so the record pointer never wraps.

The bench changes the mode only between files, holds each byte until the handshake, and uses files of a few dozen bytes. It covers marker placements, stall patterns on `out_ready`, files that end early, and a file that follows straight after another one.

// File: rtl/cfg_hdr_skip_pkg.sv
package cfg_hdr_skip_pkg;

  typedef enum logic [0:0] {
    PH_SCAN = 1'b0,
    PH_PAY  = 1'b1
  } phase_e;

  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam logic [3:0] COMP_NIB  = 4'h3;

endpackage

// File: rtl/cfg_hdr_walk.sv
module cfg_hdr_walk #(
  parameter int IDX_W   = 16,
  parameter int NREC    = 4,
  parameter int HDR_OFS = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       step,
  input  logic [7:0] cur,
  output logic       zone
);

  localparam int RC_W = $clog2(NREC + 1);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;
  localparam logic [IDX_W-1:0] OFS0 = IDX_W'(HDR_OFS);

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] rptr;
  logic [RC_W-1:0]  rcnt;
  logic             hdr_left;
  logic             at_len;

  assign hdr_left = (rcnt != RC_W'(NREC));
  assign at_len   = hdr_left && (idx == rptr);
  assign zone     = !hdr_left && (idx >= rptr);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx  <= '0;
      rptr <= OFS0;
      rcnt <= '0;
    end else if (step) begin
      if (idx != IDX_MAX) idx <= idx + 1'b1;
      if (at_len) begin
        rptr <= idx + IDX_W'(cur) + IDX_W'(3);
        rcnt <= rcnt + 1'b1;
      end
    end
  end

  AST_PTR_AHEAD: assert property (@(posedge clk) disable iff (rst)
    (step && at_len && !clr) |=> (rptr > idx)); // R2

endmodule

// File: rtl/cfg_pre_match.sv
module cfg_pre_match
  import cfg_hdr_skip_pkg::*;
#(
  parameter int PRE_LEN = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       shift,
  input  logic [7:0]                 cur,
  input  logic                       comp_mode,
  output logic                       hit_fill,
  output logic                       hit_nib,
  output logic [(PRE_LEN-1)*8-1:0]   hist_flat
);

  localparam int HIST = PRE_LEN - 1;
  localparam int HV_W = $clog2(HIST + 1);

  logic [7:0]      hist [HIST];
  logic [HV_W-1:0] hv;
  logic            all_fill;

  for (genvar k = 0; k < HIST; k++) begin : g_hist
    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst || clr)  hist[k] <= '0;
        else if (shift)  hist[k] <= cur;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst || clr)  hist[k] <= '0;
        else if (shift)  hist[k] <= hist[k-1];
      end
    end
    assign hist_flat[k*8 +: 8] = hist[k];
  end

  always_ff @(posedge clk) begin
    if (rst || clr)                        hv <= '0;
    else if (shift && hv != HV_W'(HIST))   hv <= hv + 1'b1;
  end

  always_comb begin
    all_fill = 1'b1;
    for (int k = 0; k < HIST; k++) all_fill = all_fill && (hist[k] == FILL_BYTE);
  end

  assign hit_fill = !comp_mode && (hv == HV_W'(HIST)) && all_fill && (cur == FILL_BYTE);
  assign hit_nib  = comp_mode && (hv != '0) && (hist[0] == FILL_BYTE) && (cur[7:4] == COMP_NIB);

endmodule

// File: rtl/cfg_pay_emit.sv
module cfg_pay_emit #(
  parameter int CNT_W = 16,
  parameter int REP_N = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push,
  input  logic [7:0]         push_data,
  input  logic               push_last,
  input  logic               load,
  input  logic [REP_N*8-1:0] load_data,
  input  logic               load_last,
  input  logic               arm,
  output logic               take,
  output logic               rep_busy,
  output logic               o_valid,
  input  logic               o_ready,
  output logic [7:0]         o_data,
  output logic               o_sop,
  output logic               o_last,
  output logic [CNT_W-1:0]   o_cnt
);

  localparam int RL_W = $clog2(REP_N + 1);
  localparam int RP_W = (REP_N > 1) ? $clog2(REP_N) : 1;

  logic [7:0]      rep [REP_N];
  logic [RL_W-1:0] rep_left;
  logic [RP_W-1:0] rep_pos;
  logic            rep_last;
  logic            first_pend;
  logic            slot;

  assign slot     = !o_valid || o_ready;
  assign rep_busy = (rep_left != '0);
  assign take     = slot && !rep_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid    <= 1'b0;
      o_data     <= '0;
      o_sop      <= 1'b0;
      o_last     <= 1'b0;
      o_cnt      <= '0;
      rep_left   <= '0;
      rep_pos    <= '0;
      rep_last   <= 1'b0;
      first_pend <= 1'b0;
      for (int j = 0; j < REP_N; j++) rep[j] <= '0;
    end else begin
      if (slot) begin
        if (rep_busy || push) begin
          o_valid    <= 1'b1;
          o_sop      <= first_pend;
          o_cnt      <= first_pend ? '0 : o_cnt + 1'b1;
          first_pend <= 1'b0;
          if (rep_busy) begin
            o_data   <= rep[rep_pos];
            o_last   <= rep_last && (rep_left == RL_W'(1));
            rep_left <= rep_left - 1'b1;
            rep_pos  <= rep_pos + 1'b1;
          end else begin
            o_data <= push_data;
            o_last <= push_last;
          end
        end else begin
          o_valid <= 1'b0;
        end
      end
      if (load) begin
        for (int j = 0; j < REP_N; j++) rep[j] <= load_data[j*8 +: 8];
        rep_left <= RL_W'(REP_N);
        rep_pos  <= '0;
        rep_last <= load_last;
      end
      if (load || arm) first_pend <= 1'b1;
    end
  end

  logic             need_sop;
  logic [CNT_W-1:0] prev_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      need_sop <= 1'b1;
      prev_cnt <= '0;
    end else if (o_valid && o_ready) begin
      need_sop <= o_last;
      prev_cnt <= o_cnt;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_data) && $stable(o_sop) && $stable(o_last) && $stable(o_cnt))); // R8
  AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (rst)
    push |-> take); // R8
  AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (rst)
    load |-> (!rep_busy && !push)); // R3
  AST_SOP_FIRST: assert property (@(posedge clk) disable iff (rst)
    (o_valid && need_sop) |-> (o_sop && o_cnt == '0)); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !need_sop) |-> (!o_sop && o_cnt == CNT_W'(prev_cnt + 1'b1))); // R7

endmodule

// File: rtl/cfg_hdr_skip.sv
module cfg_hdr_skip
  import cfg_hdr_skip_pkg::*;
#(
  parameter int IDX_W   = 16,
  parameter int CNT_W   = 16,
  parameter int HDR_OFS = 15,
  parameter int NREC    = 4,
  parameter int PRE_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_comp,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_sop,
  output logic             out_last,
  output logic [CNT_W-1:0] out_cnt,
  output logic             err
);

  localparam int HIST = PRE_LEN - 1;

  phase_e phase;
  logic   acc, scan_acc, zone, shift;
  logic   hit_fill, hit_nib, go_fill, go_nib, fail, clr;
  logic   take, rep_busy, push;
  logic [HIST*8-1:0]    hist_flat;
  logic [PRE_LEN*8-1:0] load_vec;

  assign in_ready = (phase == PH_SCAN) ? !rep_busy : take;
  assign acc      = in_valid && in_ready;
  assign scan_acc = acc && (phase == PH_SCAN);
  assign shift    = scan_acc && zone;
  assign go_fill  = shift && hit_fill;
  assign go_nib   = shift && hit_nib && !in_last;
  assign fail     = scan_acc && in_last && !go_fill;
  assign clr      = go_fill || go_nib || fail;
  assign push     = acc && (phase == PH_PAY);

  for (genvar j = 0; j < HIST; j++) begin : g_load
    assign load_vec[j*8 +: 8] = hist_flat[(HIST-1-j)*8 +: 8];
  end
  assign load_vec[HIST*8 +: 8] = in_data;

  cfg_hdr_walk #(
    .IDX_W   (IDX_W),
    .NREC    (NREC),
    .HDR_OFS (HDR_OFS)
  ) u_walk (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .step (scan_acc),
    .cur  (in_data),
    .zone (zone)
  );

  cfg_pre_match #(
    .PRE_LEN (PRE_LEN)
  ) u_match (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .shift     (shift),
    .cur       (in_data),
    .comp_mode (mode_comp),
    .hit_fill  (hit_fill),
    .hit_nib   (hit_nib),
    .hist_flat (hist_flat)
  );

  cfg_pay_emit #(
    .CNT_W (CNT_W),
    .REP_N (PRE_LEN)
  ) u_emit (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_data (in_data),
    .push_last (in_last),
    .load      (go_fill),
    .load_data (load_vec),
    .load_last (in_last),
    .arm       (go_nib),
    .take      (take),
    .rep_busy  (rep_busy),
    .o_valid   (out_valid),
    .o_ready   (out_ready),
    .o_data    (out_data),
    .o_sop     (out_sop),
    .o_last    (out_last),
    .o_cnt     (out_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_SCAN;
      err   <= 1'b0;
    end else begin
      err <= fail;
      case (phase)
        PH_SCAN: if ((go_fill && !in_last) || go_nib) phase <= PH_PAY;
        PH_PAY:  if (acc && in_last)                  phase <= PH_SCAN;
        default: phase <= PH_SCAN;
      endcase
    end
  end

  AST_LAST_RESTART: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_PAY && acc && in_last) |=> (phase == PH_SCAN)); // R10
  AST_ERR_SCAN: assert property (@(posedge clk) disable iff (rst)
    err |-> (phase == PH_SCAN)); // R9

endmodule

// File: tb/test_cfg_hdr_skip.sv
module test_cfg_hdr_skip;
  localparam int CLK_P = 10;
  localparam int CNT_W = 16;

  logic clk = 1'b0, rst = 1'b1, mode_comp = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_sop, out_last, err;
  logic [7:0] out_data;
  logic [CNT_W-1:0] out_cnt;

  cfg_hdr_skip i_cfg_hdr_skip (
    .clk(clk), .rst(rst), .mode_comp(mode_comp),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_last(out_last), .out_cnt(out_cnt), .err(err)
  );

  always #(CLK_P/2) clk = ~clk;

  int nrun = 0, nfail = 0;
  logic [7:0] fbuf [0:1023];
  int flen = 0;
  logic [7:0] exp_d [0:1023];
  bit exp_sop [0:1023], exp_last [0:1023];
  int exp_cnt [0:1023];
  int nexp = 0;
  logic [7:0] cap_d [0:1023];
  bit cap_sop [0:1023], cap_last [0:1023];
  int cap_cnt [0:1023];
  int ncap = 0, nerr = 0, stalls = 0, rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = lfsr[0] ^ lfsr[5];
      default: out_ready = 1'b0;
    endcase
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && out_ready && ncap < 1024) begin
        cap_d[ncap] = out_data; cap_sop[ncap] = out_sop;
        cap_last[ncap] = out_last; cap_cnt[ncap] = int'(out_cnt);
        ncap++;
      end
      if (err) nerr++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nrun++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic add(input logic [7:0] b);
    fbuf[flen] = b; flen++;
  endtask

  task automatic build_hdr(input int l0, input int l1, input int l2, input int l3);
    int base, p, lens[4];
    base = flen; lens = '{l0, l1, l2, l3};
    for (int i = 0; i < 15; i++) add((i < 4 || i % 2 == 0) ? 8'hFF : 8'h35);
    p = 15;
    for (int r = 0; r < 4; r++) begin
      add(8'(lens[r]));
      for (int q = 0; q < lens[r] + 2; q++) add((q % 5 == 4) ? 8'h32 : 8'hFF);
      p = p + lens[r] + 3;
    end
    if (flen != base + p) $display("bench header build mismatch");
  endtask

  task automatic add_payload(input int n, input int seed);
    for (int i = 0; i < n; i++) add(8'((i * 29 + seed) & 255));
  endtask

  task automatic expect_range(input int s, input int e);
    for (int i = s; i < e; i++) begin
      exp_d[nexp] = fbuf[i]; exp_sop[nexp] = (i == s);
      exp_last[nexp] = (i == e - 1); exp_cnt[nexp] = i - s;
      nexp++;
    end
  endtask

  task automatic put_byte(input logic [7:0] b, input bit last);
    bit ok;
    in_valid = 1'b1; in_data = b; in_last = last;
    do begin
      @(negedge clk);
      ok = in_ready;
      if (!ok) stalls++;
      @(posedge clk); #1;
    end while (!ok);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic send_range(input int s, input int e, input int last_at);
    for (int i = s; i < e; i++) put_byte(fbuf[i], i == last_at);
  endtask

  task automatic clear_all();
    flen = 0; nexp = 0; ncap = 0; nerr = 0; stalls = 0;
  endtask

  task automatic drain();
    rdy_mode = 0;
    repeat (300) @(posedge clk);
    #1;
  endtask

  task automatic compare(input string rs, input string rd, input string rm);
    int bad_d = 0, bad_s = 0, bad_c = 0, bad_l = 0;
    chk(ncap == nexp, rs, ncap, nexp);
    for (int i = 0; i < nexp && i < ncap; i++) begin
      if (cap_d[i] != exp_d[i]) bad_d++;
      if (cap_sop[i] != exp_sop[i]) bad_s++;
      if (cap_cnt[i] != exp_cnt[i]) bad_c++;
      if (cap_last[i] != exp_last[i]) bad_l++;
    end
    chk(bad_d == 0, {rd, " payload bytes"}, bad_d, 0);
    chk(bad_l == 0, "R6 last flag", bad_l, 0);
    chk(bad_s == 0, "R7 sop flag", bad_s, 0);
    chk(bad_c == 0, "R7 byte counter", bad_c, 0);
    chk(nerr == 0, {rm, " no error pulse"}, nerr, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(err == 1'b0, "R1 err after reset", int'(err), 0);
    @(posedge clk); #1;
  endtask

  task automatic t_plain();
    int st;
    clear_all(); mode_comp = 1'b0;
    build_hdr(3, 0, 7, 2);
    add(8'h00); add(8'h12); add(8'hFF); add(8'hFF); add(8'hFF); add(8'h00);
    add(8'hFF); add(8'h34);
    st = flen;
    repeat (4) add(8'hFF);
    add_payload(20, 7);
    expect_range(st, flen);
    send_range(0, flen, flen - 1);
    drain();
    chk(ncap == flen - st, "R2 header bytes not taken as preamble", ncap, flen - st);
    compare("R3 payload length", "R3", "R9");
  endtask

  task automatic t_align();
    int st;
    clear_all(); mode_comp = 1'b0; rdy_mode = 1;
    build_hdr(0, 4, 1, 6);
    add(8'h00); add(8'hFF); add(8'hFF); add(8'h00); add(8'hFF); add(8'hFF);
    add(8'hFF); add(8'h11);
    st = flen;
    repeat (5) add(8'hFF);
    add_payload(30, 3);
    expect_range(st, flen);
    send_range(0, flen, flen - 1);
    drain();
    compare("R5 start at first of long run", "R8", "R9");
  endtask

  task automatic t_comp();
    int st;
    clear_all(); mode_comp = 1'b1; rdy_mode = 1;
    build_hdr(1, 5, 2, 4);
    add(8'h00); add(8'hFF); add(8'h20); add(8'hFF); add(8'hFF); add(8'h3A);
    st = flen;
    add_payload(24, 90);
    expect_range(st, flen);
    send_range(0, flen, flen - 1);
    drain();
    compare("R4 payload after marker", "R4", "R9");
  endtask

  task automatic t_missing();
    clear_all(); mode_comp = 1'b0;
    build_hdr(2, 2, 2, 2);
    add(8'h00); add(8'hFF); add(8'hFF); add(8'hFF); add(8'h00); add(8'hFF);
    add(8'h3A); add(8'h01);
    send_range(0, flen, flen - 1);
    drain();
    chk(nerr == 1, "R9 error pulse, plain mode", nerr, 1);
    chk(ncap == 0, "R9 nothing forwarded, plain mode", ncap, 0);
    clear_all(); mode_comp = 1'b1;
    build_hdr(3, 1, 0, 2);
    add(8'h00); add(8'hFF); add(8'h31);
    send_range(0, flen, flen - 1);
    drain();
    chk(nerr == 1, "R9 error pulse, marker at end", nerr, 1);
    chk(ncap == 0, "R9 nothing forwarded, marker at end", ncap, 0);
  endtask

  task automatic t_b2b();
    int sa, ea, pb, sb;
    clear_all(); mode_comp = 1'b1;
    build_hdr(2, 3, 1, 0);
    add(8'hFF); add(8'h33);
    sa = flen;
    add_payload(10, 45);
    ea = flen;
    build_hdr(4, 0, 2, 5);
    add(8'h07); add(8'hFF); add(8'h3F);
    pb = flen; sb = flen;
    add_payload(12, 200);
    expect_range(sa, ea);
    expect_range(sb, flen);
    send_range(0, ea, ea - 1);
    rdy_mode = 2;
    stalls = 0;
    send_range(ea, pb, -1);
    chk(stalls == 0, "R11 header accepted while output stalled", stalls, 0);
    rdy_mode = 0;
    send_range(pb, flen, flen - 1);
    drain();
    compare("R10 two files back to back", "R10", "R10");
  endtask

  initial begin
    #(CLK_P * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_plain();
    t_align();
    t_comp();
    t_missing();
    t_b2b();
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

endmodule